// File: doc/BRIEF.md
# VLIW Bundle Length Classifier

This block examines one fetched VLIW bundle and reports how its bytes divide between a core instruction and a coprocessor instruction. The split is not fixed. It is read from bit patterns in the first four bytes of the bundle, and the rules differ between the 32-bit (4-byte) bundle mode and the 64-bit (8-byte) bundle mode. A byte-order input lets the same logic serve little-endian fetch. In that case the two bytes of every 16-bit halfword are exchanged before the patterns are tested.

A fetch stage presents a bundle with `in_valid`. One clock later the block returns the core length and the coprocessor length in bytes, together with a one-cycle `out_valid` pulse and an error flag. The control is a two-state machine. `ST_IDLE` is the state with no result being presented. `ST_EMIT` presents a result for one cycle. The transitions are:
- IDLE to EMIT when a bundle is accepted.
- EMIT to EMIT when another bundle arrives on the next cycle.
- EMIT to IDLE when no bundle arrives.

Classification works in two steps. The first step produces a split kind:
- C16+P16, C32 alone or P32 alone in 32-bit mode.
- C16+P48, C32+P32 or P64 alone in 64-bit mode.
- NONE for a reserved mode code.

The second step maps the split kind to byte counts and validates them.

Top module: `vliw_split_classifier`

## Requirements
- R1: While `rst_n` is low and after its release with no bundle accepted, `out_valid`, `out_error`, `core_len` and `cop_len` are all zero.
- R2: A bundle accepted with `in_valid` high at a rising edge produces `out_valid` high for exactly the following cycle, or for several cycles if bundles arrive back to back. Without `in_valid`, no pulse appears, and the length and error outputs keep their last values.
- R3: Byte i of the bundle sits at `bundle[8*i+7:8*i]`. With `little_endian` = 1, bytes 2k and 2k+1 are exchanged before classification. Byte h0 below is the first byte after this step.
- R4: In 32-bit mode (`mode_sel` = 2'b00), if bits 7:6 of h0 are not both 1, the result is core 2 and coprocessor 2.
- R5: In 32-bit mode with h0[7:6] = 11, h0[7:4] = 4'hF and h1[2:0] = 3'b111, the result is core 0 and coprocessor 4.
- R6: In 32-bit mode with h0[7:6] = 11 and the pattern of R5 absent, the result is core 4 and coprocessor 0.
- R7: In 64-bit mode (`mode_sel` = 2'b01), if h0[7:6] is not 11, the result is core 2 and coprocessor 6.
- R8: In 64-bit mode, the result is core 0 and coprocessor 8 when all of the following hold:
  - h0[7:4] = 4'hF.
  - h1[2:0] = 3'b111.
  - Either (h2 & 8'hFE) != 8'hF0 or (h3 & 8'hF4) != 0.
- R9: In 64-bit mode, any other bundle with h0[7:6] = 11 gives core 4 and coprocessor 4. This includes a bundle that matches the h0/h1 pattern of R8 but fails its h2/h3 test.
- R10: In 32-bit mode, bundle bytes 4 to 7 have no effect on the result.
- R11: A non-zero coprocessor length is 2, 4, 6 or 8 bytes. A non-error result sums to 4 bytes in 32-bit mode and 8 in 64-bit mode. Mode codes 2'b10 and 2'b11 are reserved; they give `out_error` = 1 with both lengths zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle present this cycle |
| mode_sel | input | 2 | 00 = 32-bit bundle, 01 = 64-bit bundle, others reserved |
| little_endian | input | 1 | Exchange bytes within halfwords before classification |
| bundle | input | 64 | Bundle bytes, byte i at bits 8i+7:8i |
| out_valid | output | 1 | Result present, one cycle per accepted bundle |
| core_len | output | 4 | Core instruction length in bytes |
| cop_len | output | 4 | Coprocessor instruction length in bytes |
| out_error | output | 1 | Mode or length combination is illegal |

## Verification
The hardest case to reach from the ports is the 64-bit exclusion. Here a bundle carries the full single-coprocessor header in its first two bytes, yet is still split as core plus coprocessor because of bytes 2 and 3. The case is harder still under little-endian order, where the swap moves the deciding bits into different port byte positions. Directed stimulus builds these bundles byte by byte. It places the header bytes in swapped positions so that only a correct halfword exchange followed by the full h2/h3 test yields the 4/4 split. Neighbouring bundles that clear exactly one masked bit, or set exactly one, show that the 8-byte coprocessor result is still reached.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    typedef enum logic [1:0] {
        MODE_W32  = 2'b00,
        MODE_W64  = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_RSV3 = 2'b11
    } bundle_mode_e;

    typedef enum logic [2:0] {
        SPLIT_C16_P16  = 3'd0,
        SPLIT_C32_ONLY = 3'd1,
        SPLIT_P32_ONLY = 3'd2,
        SPLIT_C16_P48  = 3'd3,
        SPLIT_C32_P32  = 3'd4,
        SPLIT_P64_ONLY = 3'd5,
        SPLIT_NONE     = 3'd6
    } split_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/vsc_byte_view.sv
module vsc_byte_view #(
    parameter int NBYTES = 4
) (
    input  logic                  swap_en,
    input  logic [8*NBYTES-1:0]   raw,
    output logic [8*NBYTES-1:0]   view
);
    localparam int NHALF = NBYTES / 2;

    // Each halfword is exchanged independently; no byte crosses a halfword.
    generate
        for (genvar h = 0; h < NHALF; h++) begin : g_half
            assign view[16*h+7  -: 8] = swap_en ? raw[16*h+15 -: 8] : raw[16*h+7  -: 8];
            assign view[16*h+15 -: 8] = swap_en ? raw[16*h+7  -: 8] : raw[16*h+15 -: 8];
        end
    endgenerate
endmodule

// File: rtl/vsc_split_decode.sv
module vsc_split_decode
    import vsc_pkg::*;
(
    input  bundle_mode_e  mode,
    input  logic [31:0]   hdr,
    output split_kind_e   split
);
    logic [7:0] h0, h1, h2, h3;
    logic       long_hdr;
    logic       cop_hdr;
    logic       wide_excl;

    assign h0 = hdr[7:0];
    assign h1 = hdr[15:8];
    assign h2 = hdr[23:16];
    assign h3 = hdr[31:24];

    // Top two bits 11 marks anything other than a 16-bit core lead.
    assign long_hdr  = (h0[7:6] == 2'b11);
    assign cop_hdr   = (h0[7:4] == 4'hF) && (h1[2:0] == 3'b111);
    // Pattern in bytes 2/3 that vetoes the single 64-bit coprocessor form.
    assign wide_excl = ((h2 & 8'hFE) == 8'hF0) && ((h3 & 8'hF4) == 8'h00);

    always_comb begin
        split = SPLIT_NONE;
        unique case (mode)
            MODE_W32: begin
                if (!long_hdr)     split = SPLIT_C16_P16;
                else if (cop_hdr)  split = SPLIT_P32_ONLY;
                else               split = SPLIT_C32_ONLY;
            end
            MODE_W64: begin
                if (!long_hdr)                   split = SPLIT_C16_P48;
                else if (cop_hdr && !wide_excl)  split = SPLIT_P64_ONLY;
                else                             split = SPLIT_C32_P32;
            end
            MODE_RSV2, MODE_RSV3: split = SPLIT_NONE;
        endcase
    end
endmodule

// File: rtl/vsc_len_check.sv
module vsc_len_check
    import vsc_pkg::*;
#(
    parameter int BUNDLE_BYTES = 8,
    parameter int HALF_BYTES   = 4,
    parameter int LEN_W        = 4
) (
    input  bundle_mode_e      mode,
    input  split_kind_e       split,
    output logic [LEN_W-1:0]  core_len,
    output logic [LEN_W-1:0]  cop_len,
    output logic              len_err
);
    logic [LEN_W:0] total;
    logic [LEN_W:0] want;
    logic           cop_ok;
    logic           mode_ok;

    always_comb begin
        core_len = '0;
        cop_len  = '0;
        unique case (split)
            SPLIT_C16_P16:  begin core_len = LEN_W'(2); cop_len = LEN_W'(2); end
            SPLIT_C32_ONLY: begin core_len = LEN_W'(4); cop_len = '0;        end
            SPLIT_P32_ONLY: begin core_len = '0;        cop_len = LEN_W'(4); end
            SPLIT_C16_P48:  begin core_len = LEN_W'(2); cop_len = LEN_W'(6); end
            SPLIT_C32_P32:  begin core_len = LEN_W'(4); cop_len = LEN_W'(4); end
            SPLIT_P64_ONLY: begin core_len = '0;        cop_len = LEN_W'(8); end
            default:        begin core_len = '0;        cop_len = '0;        end
        endcase
    end

    always_comb begin
        mode_ok = 1'b1;
        want    = '0;
        unique case (mode)
            MODE_W32:             want = (LEN_W+1)'(HALF_BYTES);
            MODE_W64:             want = (LEN_W+1)'(BUNDLE_BYTES);
            MODE_RSV2, MODE_RSV3: mode_ok = 1'b0;
        endcase
    end

    assign total  = {1'b0, core_len} + {1'b0, cop_len};
    assign cop_ok = (cop_len == '0) ||
                    (cop_len == LEN_W'(2)) || (cop_len == LEN_W'(4)) ||
                    (cop_len == LEN_W'(6)) || (cop_len == LEN_W'(8));
    assign len_err = !mode_ok || !cop_ok || (total != want);
endmodule

// File: rtl/vliw_split_classifier.sv
module vliw_split_classifier
    import vsc_pkg::*;
#(
    parameter int BUNDLE_BYTES = 8,
    parameter int LEN_W        = $clog2(BUNDLE_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [1:0]                mode_sel,
    input  logic                      little_endian,
    input  logic [8*BUNDLE_BYTES-1:0] bundle,
    output logic                      out_valid,
    output logic [LEN_W-1:0]          core_len,
    output logic [LEN_W-1:0]          cop_len,
    output logic                      out_error
);
    localparam int HDR_BYTES = BUNDLE_BYTES / 2;

    ctl_state_e             state_q, state_d;
    bundle_mode_e           mode;
    logic [8*HDR_BYTES-1:0] hdr_view;
    split_kind_e            split;
    logic [LEN_W-1:0]       core_d, cop_d;
    logic                   err_d;
    logic [LEN_W-1:0]       core_q, cop_q;
    logic                   err_q;
    logic                   unused_tail;

    assign mode        = bundle_mode_e'(mode_sel);
    assign unused_tail = ^bundle[8*BUNDLE_BYTES-1:8*HDR_BYTES];

    vsc_byte_view #(.NBYTES(HDR_BYTES)) u_view (
        .swap_en (little_endian),
        .raw     (bundle[8*HDR_BYTES-1:0]),
        .view    (hdr_view)
    );

    vsc_split_decode u_decode (
        .mode  (mode),
        .hdr   (hdr_view),
        .split (split)
    );

    vsc_len_check #(
        .BUNDLE_BYTES (BUNDLE_BYTES),
        .HALF_BYTES   (HDR_BYTES),
        .LEN_W        (LEN_W)
    ) u_check (
        .mode     (mode),
        .split    (split),
        .core_len (core_d),
        .cop_len  (cop_d),
        .len_err  (err_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
            cop_q  <= '0;
            err_q  <= 1'b0;
        end else if (in_valid) begin
            core_q <= core_d;
            cop_q  <= cop_d;
            err_q  <= err_d;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign core_len  = core_q;
    assign cop_len   = cop_q;
    assign out_error = err_q;

    assert_accept_pulses_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_pulse_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(core_len) && $stable(cop_len) && $stable(out_error)));
    assert_sum_fits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error) |->
        (({1'b0, core_len} + {1'b0, cop_len}) ==
         (($past(mode_sel) == 2'b01) ? (LEN_W+1)'(BUNDLE_BYTES) : (LEN_W+1)'(HDR_BYTES))));
    assert_error_zero_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_error) |-> (core_len == '0 && cop_len == '0));
    assert_cop_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cop_len != '0) |-> (cop_len[0] == 1'b0));
endmodule

// File: tb/vliw_split_classifier_bench.sv
module vliw_split_classifier_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  mode_sel;
    logic        little_endian;
    logic [63:0] bundle;
    logic        out_valid;
    logic [3:0]  core_len, cop_len;
    logic        out_error;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    vliw_split_classifier u_vliw_split_classifier (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
        .little_endian(little_endian), .bundle(bundle), .out_valid(out_valid),
        .core_len(core_len), .cop_len(cop_len), .out_error(out_error)
    );

    function automatic logic [63:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
        return {b7, b6, b5, b4, b3, b2, b1, b0};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one bundle, check the result cycle and the following idle cycle.
    task automatic run(input string req, input logic [1:0] m, input logic le,
                       input logic [63:0] b, input int ecore, input int ecop, input int eerr);
        @(negedge clk);
        in_valid = 1'b1; mode_sel = m; little_endian = le; bundle = b;
        @(posedge clk); #1;
        chk({req, " valid"}, out_valid, 1);
        chk({req, " core"},  core_len,  ecore);
        chk({req, " cop"},   cop_len,   ecop);
        chk({req, " err"},   out_error, eerr);
        @(negedge clk);
        in_valid = 1'b0; bundle = ~b; mode_sel = 2'b01; little_endian = ~le;
        @(posedge clk); #1;
        chk("R2 pulse ends", out_valid, 0);
        chk("R2 hold core",  core_len,  ecore);
        chk("R2 hold cop",   cop_len,   ecop);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; mode_sel = 2'b00; little_endian = 1'b0; bundle = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid", out_valid, 0);
        chk("R1 err",   out_error, 0);
        chk("R1 core",  core_len,  0);
        chk("R1 cop",   cop_len,   0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 idle valid", out_valid, 0);
        chk("R1 idle core",  core_len,  0);
    endtask

    task automatic t_w32();
        run("R4 top 10", 2'b00, 1'b0, mk(8'h80,0,0,0,0,0,0,0), 2, 2, 0);
        run("R4 top 00", 2'b00, 1'b0, mk(8'h3F,8'hFF,0,0,0,0,0,0), 2, 2, 0);
        run("R5 cop32",  2'b00, 1'b0, mk(8'hF5,8'h07,0,0,0,0,0,0), 0, 4, 0);
        run("R5 cop32b", 2'b00, 1'b0, mk(8'hFF,8'hFF,0,0,0,0,0,0), 0, 4, 0);
        run("R6 core32", 2'b00, 1'b0, mk(8'hF0,8'h06,0,0,0,0,0,0), 4, 0, 0);
        run("R6 core32b",2'b00, 1'b0, mk(8'hC0,8'h07,0,0,0,0,0,0), 4, 0, 0);
    endtask

    task automatic t_endian();
        run("R3 le cop32", 2'b00, 1'b1, mk(8'h07,8'hF3,0,0,0,0,0,0), 0, 4, 0);
        run("R3 be same",  2'b00, 1'b0, mk(8'h07,8'hF3,0,0,0,0,0,0), 2, 2, 0);
        run("R3 le excl",  2'b01, 1'b1, mk(8'h07,8'hFF,8'h00,8'hF0,0,0,0,0), 4, 4, 0);
        run("R3 le p64",   2'b01, 1'b1, mk(8'h07,8'hFF,8'h04,8'hF0,0,0,0,0), 0, 8, 0);
    endtask

    task automatic t_w64();
        run("R7 c16p48", 2'b01, 1'b0, mk(8'h40,8'h07,0,0,0,0,0,0), 2, 6, 0);
        run("R8 p64",    2'b01, 1'b0, mk(8'hFF,8'h07,8'h00,8'h00,0,0,0,0), 0, 8, 0);
        run("R8 p64 b3", 2'b01, 1'b0, mk(8'hF0,8'h0F,8'hF0,8'h04,0,0,0,0), 0, 8, 0);
        run("R8 p64 b2", 2'b01, 1'b0, mk(8'hF0,8'h07,8'hF2,8'h00,0,0,0,0), 0, 8, 0);
        run("R9 excl",   2'b01, 1'b0, mk(8'hFF,8'h07,8'hF1,8'h0B,0,0,0,0), 4, 4, 0);
        run("R9 c32p32", 2'b01, 1'b0, mk(8'hD0,8'h07,0,0,0,0,0,0), 4, 4, 0);
    endtask

    task automatic t_tail_ignored();
        run("R10 tail a", 2'b00, 1'b0, mk(8'h80,0,0,0,8'hFF,8'h07,8'hFF,8'hFF), 2, 2, 0);
        run("R10 tail b", 2'b00, 1'b0, mk(8'hF5,8'h07,0,0,8'h12,8'h34,8'h56,8'h78), 0, 4, 0);
    endtask

    task automatic t_reserved();
        run("R11 mode10", 2'b10, 1'b0, mk(8'h80,0,0,0,0,0,0,0), 0, 0, 1);
        run("R11 mode11", 2'b11, 1'b0, mk(8'hFF,8'h07,0,0,0,0,0,0), 0, 0, 1);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        in_valid = 1'b1; mode_sel = 2'b01; little_endian = 1'b0;
        bundle = mk(8'h40,0,0,0,0,0,0,0);
        @(posedge clk); #1;
        chk("R2 b2b first valid", out_valid, 1);
        chk("R7 b2b first cop",   cop_len,   6);
        @(negedge clk);
        bundle = mk(8'hFF,8'h07,0,0,0,0,0,0);
        @(posedge clk); #1;
        chk("R2 b2b second valid", out_valid, 1);
        chk("R8 b2b second cop",   cop_len,   8);
        chk("R8 b2b second core",  core_len,  0);
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        chk("R2 b2b end", out_valid, 0);
    endtask

    initial begin
        t_reset();
        t_w32();
        t_endian();
        t_w64();
        t_tail_ignored();
        t_reserved();
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule